// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between an internal request bus and an external asynchronous static RAM of 256K words by 16 bits with separate low-byte and high-byte enables. One read or write request is taken per handshake. The controller then sequences the chip select, write enable, output enable and the two byte-lane enables, and it presents the address. The bidirectional data bus is handled as a driven value, a drive-enable and a separate input path, so that the pad ring can build the tri-state buffer.

A write goes through three timed phases. In the setup phase the address and data are presented while the strobes stay inactive. In the pulse phase chip select and write enable are low together. In the recovery phase the strobes are high again while the address is held and the data is kept for its hold time. Because write enable falls no later than chip select, the memory keeps its outputs in high impedance for the whole write. A read holds chip select and output enable low for a fixed access latency. It then samples the enabled lanes and returns them with a one-cycle valid pulse. Every phase length is an integer parameter counted in clock cycles.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, chip select, write enable, output enable and both lane enables are high, the data drive-enable is low, `req_ready` is high and `rsp_valid` is low.
- R2: A write accepted at a clock edge gives T_AS cycles with strobes high, then max(T_WP,T_DS) cycles with `mem_cs_n` and `mem_we_n` both low, then max(T_DH,T_WR) cycles with both high again. Output enable stays high for the whole write.
- R3: Write enable never falls while chip select is already low; it falls in the same cycle as chip select.
- R4: Request byte-enable bit 0 selects the low lane (data bits 7:0, `mem_lb_n` low) and bit 1 selects the high lane (bits 15:8, `mem_ub_n` low), for the whole transaction. A write changes only the selected lanes of the memory word, and a write with no lane selected changes none.
- R5: The data bus is driven with the request data from the first setup cycle until T_DH cycles after the write pulse ends. It is never driven while output enable is low.
- R6: A read holds `mem_cs_n` and `mem_oe_n` low, with `mem_we_n` high, for T_RD cycles. `rsp_valid` is then high for exactly one cycle, and `rsp_rdata` carries the selected lanes of `mem_dq_in` sampled in the last access cycle, with unselected lanes zero.
- R7: `req_ready` is low from the acceptance edge until the write recovery ends or until the cycle in which read data is returned. A request presented while `req_ready` is low has no effect.
- R8: Between the last cycle the data bus is driven and a cycle with output enable low there is at least one cycle with neither.
- R9: `mem_addr` holds the accepted address, unchanged, for every cycle of a transaction, including the setup phase and the recovery phase, even if `req_addr` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane select, bit 0 low byte, bit 1 high byte, active high |
| rsp_valid | output | 1 | Read data valid, one-cycle pulse |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| mem_addr | output | 18 | Memory address |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_lb_n | output | 1 | Low byte enable, active low |
| mem_ub_n | output | 1 | High byte enable, active low |
| mem_dq_out | output | 16 | Data driven toward memory |
| mem_dq_oe | output | 1 | Drive-enable for the data bus |
| mem_dq_in | input | 16 | Data returned from memory |

## Verification
The return of read data and the acceptance of the next request fall in the same cycle. `rsp_valid` is high in the same idle cycle where `req_ready` rises, so a request that is already waiting is taken while the previous result is being delivered. The bench provokes this by holding `req_valid` high through back-to-back reads and writes. A per-cycle reference model then judges the pulse, the data, the acceptance edge, and the gap before output enable falls again.

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl #(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned T_AS   = 1,
  parameter int unsigned T_WP   = 2,
  parameter int unsigned T_DS   = 1,
  parameter int unsigned T_DH   = 1,
  parameter int unsigned T_WR   = 1,
  parameter int unsigned T_RD   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_be,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic              mem_lb_n,
  output logic              mem_ub_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int unsigned HALF  = DATA_W / 2;
  localparam int unsigned P_LEN = (T_WP > T_DS) ? T_WP : T_DS;
  localparam int unsigned H_LEN = (T_DH > T_WR) ? T_DH : T_WR;
  localparam int unsigned M_AP  = (T_AS > P_LEN) ? T_AS : P_LEN;
  localparam int unsigned M_HR  = (H_LEN > T_RD) ? H_LEN : T_RD;
  localparam int unsigned MAXL  = (M_AP > M_HR) ? M_AP : M_HR;
  localparam int unsigned CNT_W = $clog2(MAXL + 1);
  localparam logic [CNT_W-1:0] LD_AS  = CNT_W'(T_AS - 1);
  localparam logic [CNT_W-1:0] LD_P   = CNT_W'(P_LEN - 1);
  localparam logic [CNT_W-1:0] LD_H   = CNT_W'(H_LEN - 1);
  localparam logic [CNT_W-1:0] LD_RD  = CNT_W'(T_RD - 1);
  localparam logic [CNT_W-1:0] H_CUT  = CNT_W'(H_LEN - T_DH);

  typedef enum logic [2:0] {S_IDLE, S_WSET, S_WPUL, S_WHLD, S_RACC} phase_t;

  phase_t             state;
  logic [CNT_W-1:0]   cnt;
  logic [ADDR_W-1:0]  addr_q;
  logic [DATA_W-1:0]  data_q;
  logic [1:0]         be_q;
  logic               last;

  assign last = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      addr_q    <= '0;
      data_q    <= '0;
      be_q      <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state)
        S_IDLE: if (req_valid) begin
          addr_q <= req_addr;
          data_q <= req_wdata;
          be_q   <= req_be;
          if (req_write) begin
            state <= S_WSET;
            cnt   <= LD_AS;
          end else begin
            state <= S_RACC;
            cnt   <= LD_RD;
          end
        end
        S_WSET: if (last) begin
          state <= S_WPUL;
          cnt   <= LD_P;
        end else cnt <= cnt - 1'b1;
        S_WPUL: if (last) begin
          state <= S_WHLD;
          cnt   <= LD_H;
        end else cnt <= cnt - 1'b1;
        S_WHLD: if (last) state <= S_IDLE;
                else cnt <= cnt - 1'b1;
        S_RACC: if (last) begin
          state     <= S_IDLE;
          rsp_valid <= 1'b1;
          rsp_rdata <= {be_q[1] ? mem_dq_in[DATA_W-1:HALF] : {HALF{1'b0}},
                        be_q[0] ? mem_dq_in[HALF-1:0]      : {HALF{1'b0}}};
        end else cnt <= cnt - 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready  = (state == S_IDLE);
  assign mem_addr   = addr_q;
  assign mem_dq_out = data_q;
  assign mem_cs_n   = !(state == S_WPUL || state == S_RACC);
  assign mem_we_n   = (state != S_WPUL);
  assign mem_oe_n   = (state != S_RACC);
  assign mem_lb_n   = !(!req_ready && be_q[0]);
  assign mem_ub_n   = !(!req_ready && be_q[1]);
  assign mem_dq_oe  = (state == S_WSET) || (state == S_WPUL) ||
                      (state == S_WHLD && cnt >= H_CUT);

  assert_no_contention_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dq_oe);

  assert_drive_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && !mem_we_n) |-> mem_dq_oe);

  assert_we_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> $fell(mem_cs_n));

  assert_release_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> !$past(mem_dq_oe));

  assert_addr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $past(!req_ready)) |-> $stable(mem_addr));

  assert_rsp_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_busy_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs_n |-> !req_ready);

endmodule

// File: tb/tb_sram_lane_ctrl.sv
module tb_sram_lane_ctrl;
  localparam int AS = 2, WP = 3, DS = 2, DH = 1, WR = 2, RD = 2;
  localparam int PL = (WP > DS) ? WP : DS;
  localparam int HL = (DH > WR) ? DH : WR;
  localparam int WEND = AS + PL + HL;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic req_ready, rsp_valid, mem_cs_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe;
  logic [15:0] rsp_rdata, mem_dq_out;
  logic [15:0] mem_dq_in = '0;
  logic [17:0] mem_addr;

  always #5 clk = ~clk;

  sram_lane_ctrl #(.ADDR_W(18), .DATA_W(16), .T_AS(AS), .T_WP(WP), .T_DS(DS),
                   .T_DH(DH), .T_WR(WR), .T_RD(RD)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

  int total = 0, bad = 0, cycles = 0;
  logic [15:0] chip [int];
  logic [15:0] refm [int];

  int op = 0, t = 0;
  logic [17:0] m_addr;
  logic [15:0] m_data, rd_exp;
  logic [1:0]  m_be;
  logic        rsp_exp = 1'b0;

  function automatic logic [15:0] lanes(logic [15:0] v, logic [1:0] b);
    return {b[1] ? v[15:8] : 8'h00, b[0] ? v[7:0] : 8'h00};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s t=%0d actual=%h expected=%h @%0t", req, t, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op = 0; t = 0; rsp_exp = 1'b0;
    end else begin
      rsp_exp = 1'b0;
      if (op == 0) begin
        if (req_valid) begin
          op = req_write ? 1 : 2; t = 1;
          m_addr = req_addr; m_data = req_wdata; m_be = req_be;
          if (req_write) begin
            logic [15:0] old;
            old = refm.exists(int'(req_addr)) ? refm[int'(req_addr)] : 16'h0;
            if (req_be[0]) old[7:0] = req_wdata[7:0];
            if (req_be[1]) old[15:8] = req_wdata[15:8];
            refm[int'(req_addr)] = old;
          end
        end
      end else if (t == ((op == 1) ? WEND : RD)) begin
        if (op == 2) begin
          rsp_exp = 1'b1;
          rd_exp = lanes(refm.exists(int'(m_addr)) ? refm[int'(m_addr)] : 16'h0, m_be);
        end
        op = 0;
      end else t++;
    end
  end

  always @(negedge clk) begin
    logic e_cs, e_we, e_oe, e_oe_d;
    cycles++;
    if (cycles > 150000) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
    if (rst_n) begin
      e_cs = 1'b1; e_we = 1'b1; e_oe = 1'b1; e_oe_d = 1'b0;
      if (op == 1) begin
        e_oe_d = (t <= AS + PL + DH);
        if (t > AS && t <= AS + PL) begin e_cs = 1'b0; e_we = 1'b0; end
      end else if (op == 2) begin
        e_cs = 1'b0; e_oe = 1'b0;
      end
      chk("R7 ready", req_ready, op == 0);
      chk("R2 cs_n", mem_cs_n, e_cs);
      chk("R3 we_n", mem_we_n, e_we);
      chk("R6 oe_n", mem_oe_n, e_oe);
      chk("R5 dq_oe", mem_dq_oe, e_oe_d);
      chk("R4 lb_n", mem_lb_n, !(op != 0 && m_be[0]));
      chk("R4 ub_n", mem_ub_n, !(op != 0 && m_be[1]));
      chk("R6 rsp_valid", rsp_valid, rsp_exp);
      if (rsp_exp) chk("R6 rdata", rsp_rdata, rd_exp);
      if (op != 0) chk("R9 addr", mem_addr, m_addr);
      if (e_oe_d) chk("R5 dq_out", mem_dq_out, m_data);
      if (!mem_oe_n) chk("R8 gap", mem_dq_oe, 1'b0);
    end
    if (!mem_cs_n && !mem_we_n && mem_dq_oe) begin
      logic [15:0] w;
      w = chip.exists(int'(mem_addr)) ? chip[int'(mem_addr)] : 16'h0;
      if (!mem_lb_n) w[7:0] = mem_dq_out[7:0];
      if (!mem_ub_n) w[15:8] = mem_dq_out[15:8];
      chip[int'(mem_addr)] = w;
    end
    if (!mem_cs_n && mem_we_n && !mem_oe_n) begin
      logic [15:0] r;
      r = chip.exists(int'(mem_addr)) ? chip[int'(mem_addr)] : 16'h0;
      mem_dq_in = {mem_ub_n ? 8'h00 : r[15:8], mem_lb_n ? 8'h00 : r[7:0]};
    end else mem_dq_in = 16'h0;
  end

  task automatic issue(logic w, logic [17:0] a, logic [15:0] d, logic [1:0] b);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_be = b;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic quiet(int n);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 cs_n", mem_cs_n, 1'b1);
    chk("R1 we_n", mem_we_n, 1'b1);
    chk("R1 oe_n", mem_oe_n, 1'b1);
    chk("R1 lanes", {mem_lb_n, mem_ub_n}, 2'b11);
    chk("R1 dq_oe", mem_dq_oe, 1'b0);
    chk("R1 ready", req_ready, 1'b1);
    chk("R1 rsp", rsp_valid, 1'b0);
    rst_n = 1'b1;
    quiet(2);
    issue(1'b1, 18'h00000, 16'hA55A, 2'b11); quiet(12);
    issue(1'b0, 18'h00000, 16'h0000, 2'b11); quiet(6);
    issue(1'b1, 18'h3FFFF, 16'h1234, 2'b01); quiet(12);
    issue(1'b1, 18'h3FFFF, 16'hBEEF, 2'b10); quiet(12);
    issue(1'b0, 18'h3FFFF, 16'h0000, 2'b11); quiet(6);
    issue(1'b0, 18'h3FFFF, 16'h0000, 2'b01); quiet(6);
    issue(1'b1, 18'h00000, 16'hFFFF, 2'b00); quiet(12);
    issue(1'b0, 18'h00000, 16'h0000, 2'b11); quiet(6);
    // back-to-back: held valid, pending payload must wait (R7), read return overlaps acceptance (R6)
    issue(1'b0, 18'h00000, 16'h0000, 2'b11);
    issue(1'b0, 18'h3FFFF, 16'h0000, 2'b10);
    issue(1'b1, 18'h00123, 16'h7788, 2'b11);
    issue(1'b0, 18'h00123, 16'h0000, 2'b11);
    issue(1'b1, 18'h00124, 16'h99AA, 2'b01);
    quiet(12);
    for (int i = 0; i < 400; i++) begin
      logic [17:0] a;
      a = ($urandom % 4 == 0) ? 18'h3FFFF : 18'($urandom % 8);
      issue(1'($urandom), a, 16'($urandom), 2'($urandom));
      if ($urandom % 3 == 0) quiet(1 + $urandom % 3);
    end
    quiet(12);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule